// File: doc/BRIEF.md
# Nine-Level Reversing-Bridge PWM Gate Generator

This block produces the gate pattern for a single-phase nine-level inverter built from two stages. The first stage is a level builder that stacks unit DC sources and only ever produces a non-negative magnitude of 0 to 4 units. The second stage is a full bridge that sets the sign of that magnitude. A signed sampled reference comes in every clock. The block compares its absolute value against four level-shifted triangular carriers that share one up/down counter. The number of carriers below the magnitude is the commanded level. That level selects a fixed switch set for the level builder. The sign of the reference selects one diagonal of the bridge.

The bridge may only change diagonal while the commanded level is 0, so it switches once per half line cycle and never while the level builder is sourcing voltage. Every change of the applied gate vector goes through a dead-time sequencer. Gates that leave the pattern drop at once. Gates that join the pattern wait a programmable number of cycles, during which only the gates common to the old and new patterns stay on.

Top module: `rv_pwm9`

## Requirements
- R1: While reset is held, all twelve gate outputs are 0.
- R2: The commanded level is the count of carriers k (k = 0..3) with |ref| > k*32 + t, where t is a triangle that runs 0..31 and back. A reference of ±32·n (n = 0..3) and −128 therefore hold a constant level of n (4 for −128), the same level for either sign.
- R3: Level gate bit i drives level switch i+1. The level sets are: level 0 = 0x1E, level 1 = 0x2E, level 2 = 0xA6, level 3 = 0x62, level 4 = 0x21.
- R4: Bridge gate bits are [0] left-high, [1] left-low, [2] right-high, [3] right-low. Non-negative polarity drives 4'b1001 and negative polarity drives 4'b0110. No leg ever has both of its devices on.
- R5: The bridge polarity follows the reference sign only in a cycle where the registered level is 0. A sign change that never passes through level 0 leaves the bridge unchanged.
- R6: With zero dead time and a constant reference inside the lowest band, the level-1 set is applied for 31 out of every 62 cycles at |ref| = 16, and for 15 out of 62 at |ref| = 8. The rest of the time the level-0 set is applied.
- R7: With dead time D > 0, a pattern change first shows only the gates common to the old and new patterns for exactly D cycles, then shows the new pattern. This applies to bridge gates and level gates alike. No gate turns on in a cycle in which another turns off.
- R8: With dead time 0, the new pattern is applied directly and no intermediate pattern appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_i | input | REF_W (8) | Signed reference sample, two's complement |
| dead_i | input | DT_W (4) | Dead time in clock cycles |
| lvl_gate_o | output | 8 | Level-builder gate drives, bit i = switch i+1 |
| pol_gate_o | output | 4 | Polarity bridge gate drives |

## Verification
Steady references at multiples of 32 of both signs pin each level to a constant set. This separates the carrier count and the switch-set table from the modulation itself. A walk from positive to negative through levels that skip 0 tells a correctly gated polarity register apart from one that follows the sign freely. A short excursion to −1 lets the bridge flip. Constant references of 16, 8 and −16 with zero dead time measure duty over whole carrier periods, which tests the triangle shape and the comparison. Single steps at dead times of 0, 3, 4 and 5 count the overlap cycles on level and bridge transitions.

// File: rtl/rv_pwm9.sv
module rv_pwm9 #(
  parameter int REF_W = 8,
  parameter int DT_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [REF_W-1:0] ref_i,
  input  logic [DT_W-1:0]         dead_i,
  output logic [7:0]              lvl_gate_o,
  output logic [3:0]              pol_gate_o
);
  localparam int TRI_W = REF_W - 3;
  localparam int BAND  = 1 << TRI_W;
  localparam int NCAR  = 4;
  localparam logic [3:0] BR_POS = 4'b1001;
  localparam logic [3:0] BR_NEG = 4'b0110;

  logic [TRI_W-1:0] tri_q;
  logic             up_q;
  logic [REF_W-1:0] mag;
  logic [NCAR-1:0]  above;
  logic [2:0]       lvl_d, lvl_q;
  logic             pol_q;
  logic [11:0]      tgt, cur_q, pend_q, gates;
  logic             busy_q;
  logic [DT_W-1:0]  cnt_q;

  assign mag = ref_i[REF_W-1] ? (~$unsigned(ref_i) + 1'b1) : $unsigned(ref_i);

  for (genvar k = 0; k < NCAR; k++) begin : g_car
    assign above[k] = mag > (REF_W'(k * BAND) + REF_W'(tri_q));
  end

  always_comb begin
    lvl_d = '0;
    for (int k = 0; k < NCAR; k++) lvl_d = lvl_d + 3'(above[k]);
  end

  function automatic logic [7:0] set_of(input logic [2:0] l);
    case (l)
      3'd0:    set_of = 8'h1E;
      3'd1:    set_of = 8'h2E;
      3'd2:    set_of = 8'hA6;
      3'd3:    set_of = 8'h62;
      default: set_of = 8'h21;
    endcase
  endfunction

  assign tgt = {pol_q ? BR_NEG : BR_POS, set_of(lvl_q)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tri_q  <= '0;
      up_q   <= 1'b1;
      lvl_q  <= '0;
      pol_q  <= 1'b0;
      cur_q  <= '0;
      pend_q <= '0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (up_q) begin
        if (tri_q == TRI_W'(BAND - 1)) begin
          up_q  <= 1'b0;
          tri_q <= tri_q - 1'b1;
        end else tri_q <= tri_q + 1'b1;
      end else begin
        if (tri_q == '0) begin
          up_q  <= 1'b1;
          tri_q <= tri_q + 1'b1;
        end else tri_q <= tri_q - 1'b1;
      end

      lvl_q <= lvl_d;
      if (lvl_q == 3'd0) pol_q <= ref_i[REF_W-1];

      if (busy_q) begin
        if (cnt_q <= DT_W'(1)) begin
          cur_q  <= pend_q;
          busy_q <= 1'b0;
        end
        cnt_q <= cnt_q - 1'b1;
      end else if (tgt != cur_q) begin
        if (dead_i == '0) cur_q <= tgt;
        else begin
          pend_q <= tgt;
          cnt_q  <= dead_i;
          busy_q <= 1'b1;
        end
      end
    end
  end

  assign gates = busy_q ? (cur_q & pend_q) : cur_q;
  assign {pol_gate_o, lvl_gate_o} = gates;

  assert_gates_off_in_reset_R1: assert property (@(posedge clk)
    $past(!rst_n) && !rst_n |-> gates == '0);

  assert_band_count_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lvl_gate_o) <= 4 && lvl_q <= 3'd4);

  assert_leg_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(pol_gate_o[0] && pol_gate_o[1]) && !(pol_gate_o[2] && pol_gate_o[3]));

  assert_polarity_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pol_q != $past(pol_q) |-> $past(lvl_q) == 3'd0);

  assert_no_overlap_turnon_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dead_i != '0) && ((gates & ~$past(gates)) != '0) |-> ((~gates & $past(gates)) == '0));
endmodule

// File: tb/sim_rv_pwm9.sv
module sim_rv_pwm9;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic signed [7:0] ref_i = '0;
  logic [3:0]        dead_i = 4'd2;
  logic [7:0]        lvl_gate_o;
  logic [3:0]        pol_gate_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [11:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  rv_pwm9 u0 (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .dead_i(dead_i),
    .lvl_gate_o(lvl_gate_o), .pol_gate_o(pol_gate_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] br, input logic [7:0] lv, input string tag);
    item_t it;
    it.exp = {br, lv};
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic hold(input logic signed [7:0] r, input int n,
                      input logic [3:0] br, input logic [7:0] lv, input string tag);
    ref_i = r;
    step(n);
    push(br, lv, tag);
    step(1);
  endtask

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check({pol_gate_o, lvl_gate_o} === it.exp, it.tag,
            int'({pol_gate_o, lvl_gate_o}), int'(it.exp));
    end
  end

  task automatic count_lvl(input int n, input logic [7:0] pat, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (lvl_gate_o === pat) c++;
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    int c;
    int pc;
    step(5);
    push(4'h0, 8'h00, "R1 gates off in reset");
    step(2);
    rst_n = 1'b1;

    hold(8'sd0,   30, 4'b1001, 8'h1E, "R3 level0 set");
    hold(8'sd32,  30, 4'b1001, 8'h2E, "R2 R3 level1 set");
    hold(8'sd64,  30, 4'b1001, 8'hA6, "R2 R3 level2 set");
    hold(8'sd96,  30, 4'b1001, 8'h62, "R2 R3 level3 set");
    hold(-8'sd128, 30, 4'b1001, 8'h21, "R5 R3 level4 bridge kept");
    hold(-8'sd64, 30, 4'b1001, 8'hA6, "R5 sign change without zero");
    hold(-8'sd1, 200, 4'b0110, 8'h1E, "R4 negative diagonal");
    hold(-8'sd64, 30, 4'b0110, 8'hA6, "R2 R4 negative level2");
    hold(-8'sd32, 30, 4'b0110, 8'h2E, "R2 negative level1");
    hold(-8'sd96, 30, 4'b0110, 8'h62, "R2 negative level3");
    hold(8'sd32,  30, 4'b0110, 8'h2E, "R5 positive without zero");
    hold(8'sd0,   30, 4'b1001, 8'h1E, "R4 R5 back positive at zero");

    dead_i = 4'd4;
    step(2);
    ref_i = -8'sd32;
    pc = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (pol_gate_o === 4'b0000) pc++;
    end
    check(pc == 4, "R7 bridge dead gap", pc, 4);
    push(4'b0110, 8'h2E, "R7 bridge after gap");
    step(1);

    hold(8'sd0, 40, 4'b1001, 8'h1E, "R4 positive again");
    dead_i = 4'd3;
    step(2);
    ref_i = 8'sd32;
    count_lvl(30, 8'h0E, c);
    check(c == 3, "R7 level gap D=3", c, 3);
    push(4'b1001, 8'h2E, "R7 level after gap");
    step(1);

    dead_i = 4'd5;
    step(2);
    ref_i = 8'sd64;
    count_lvl(30, 8'h26, c);
    check(c == 5, "R7 level gap D=5", c, 5);
    push(4'b1001, 8'hA6, "R7 level2 after gap");
    step(1);

    hold(8'sd0, 40, 4'b1001, 8'h1E, "R3 level0 before zero dead");
    dead_i = 4'd0;
    step(2);
    ref_i = 8'sd32;
    count_lvl(30, 8'h0E, c);
    check(c == 0, "R8 no intermediate", c, 0);
    push(4'b1001, 8'h2E, "R8 direct level1");
    step(1);

    ref_i = 8'sd16;
    step(100);
    count_lvl(620, 8'h2E, c);
    check(c == 310, "R6 duty at 16", c, 310);
    count_lvl(620, 8'h1E, c);
    check(c == 310, "R6 low part at 16", c, 310);

    ref_i = 8'sd8;
    step(100);
    count_lvl(620, 8'h2E, c);
    check(c == 150, "R6 duty at 8", c, 150);

    ref_i = -8'sd16;
    step(200);
    c = 0;
    pc = 0;
    for (int i = 0; i < 620; i++) begin
      @(negedge clk);
      if (lvl_gate_o === 8'h2E) c++;
      if (pol_gate_o === 4'b0110) pc++;
    end
    check(c == 310, "R6 duty at -16", c, 310);
    check(pc == 620, "R4 negative bridge during pwm", pc, 620);

    step(3);
    wait (sb.size() == 0);
    step(1);
    done = 1;
    finish_run();
  end
endmodule